// File: doc/BRIEF.md
# Serial Flash Status Read Responder

This block is the device-side logic that answers a status-read command on a four-wire serial link. A host pulls the chip select low and clocks in an 8-bit command, most significant bit first. If that command matches the status-read code, the block streams back one status byte, most significant bit first. It keeps sending the same byte layout over and over for as long as the select stays low and the serial clock keeps running. The host can therefore poll the device without issuing the command again.

The status byte has four parts. Bit 7 is the ready flag, bit 6 is the compare-mismatch flag, bits 5 to 2 hold a fixed density code, and bits 1 and 0 are reserved. The ready flag and the compare flag come in as live inputs from the rest of the device. A new copy of the status is taken at the start of every pass. The ready bit is special: while it sits on the output line it follows the ready input directly. A host that stops the clock low after bit 7 therefore sees the line rise as soon as the device becomes ready.

The serial clock, select and data input are sampled by a faster local clock through synchronizer stages, so all logic runs in one clock domain. Commands are sampled on serial clock rising edges and output bits change on falling edges. This works for both idle-low and idle-high clock polarity.

Top module: `flash_status_responder`

## Requirements
- R1: After reset, and on any cycle where the synchronized select is high, `so_oe` is 0 and `so` is 0.
- R2: The command is taken MSB first on serial clock rising edges. When the eighth bit completes a value equal to `CMD_RDSR` (default 8'hD7), the next serial clock falling edge sets `so_oe` to 1 and puts status bit 7 on `so`.
- R3: If the eight command bits do not equal `CMD_RDSR`, `so_oe` stays 0 for the rest of that select-low frame, however many clocks follow.
- R4: The status byte is {ready, compare-miss, DENSITY[3:0], 2'b00}, with DENSITY defaulting to 4'b1011. It goes out one bit per falling edge, bit 7 first. Ready=1 means ready and ready=0 means busy. Compare-miss=1 means a mismatch.
- R5: After bit 0 has been driven, the next falling edge drives bit 7 again. The byte repeats without limit while select is low.
- R6: Bits 6 to 0 of each pass carry the compare-miss input and constants as they were at the falling edge that began that pass. A change during a pass shows in the next pass and not in the current one.
- R7: While bit 7 is on `so` and the serial clock is held, `so` follows `dev_ready`. It goes from 0 to 1 within two local clocks of `dev_ready` rising.
- R8: Select going high ends the frame and clears the command and bit state. The next frame must start with a full command again before anything is driven.
- R9: Frames behave the same whether the serial clock idles low or idles high while select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select from the host |
| si | input | 1 | Serial command data from the host |
| dev_ready | input | 1 | 1 when the device is idle and able to take a command |
| cmp_miss | input | 1 | 1 when the latest page-to-buffer compare found a difference |
| so | output | 1 | Serial status data to the host |
| so_oe | output | 1 | Drive enable for `so`; 0 means the pin is released |

## Verification
The main path is driven with the matching command under every combination of the ready and compare inputs. This separates the two live bits from each other and from the fixed code. Each frame reads two full passes to show the byte repeats. Several near-miss commands, one differing only in the last bit, plus all-zero and all-one codes, show that only the exact code turns on the output. Both clock idle levels are mixed into the table. Directed frames then change inputs mid-pass to tell the per-pass copy apart from the live ready bit, and abort a frame mid-byte to show that the next frame starts clean.

// File: rtl/flash_status_responder.sv
module flash_status_responder #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CMD_RDSR    = 8'hD7,
  parameter logic [3:0]  DENSITY     = 4'b1011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic dev_ready,
  input  logic cmp_miss,
  output logic so,
  output logic so_oe
);

  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  typedef enum logic [1:0] {PH_CMD, PH_STAT, PH_SKIP} phase_t;

  logic [NS-1:0] sck_sr, cs_sr, si_sr;
  logic          sck_q;
  logic          sck_s, cs_s, si_s;
  logic          sck_rise, sck_fall;

  phase_t        phase;
  logic [2:0]    cmd_cnt;
  logic [6:0]    cmd_sr;
  logic          out_on;
  logic [2:0]    idx;
  logic [7:0]    snap;
  logic [7:0]    live;
  logic [7:0]    cmd_full;

  assign sck_s    = sck_sr[NS-1];
  assign cs_s     = cs_sr[NS-1];
  assign si_s     = si_sr[NS-1];
  assign sck_rise =  sck_s & ~sck_q;
  assign sck_fall = ~sck_s &  sck_q;
  assign live     = {dev_ready, cmp_miss, DENSITY, 2'b00};
  assign cmd_full = {cmd_sr, si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      si_sr  <= '0;
      sck_q  <= 1'b0;
    end else begin
      sck_sr <= {sck_sr[NS-2:0], sck};
      cs_sr  <= {cs_sr[NS-2:0], cs_n};
      si_sr  <= {si_sr[NS-2:0], si};
      sck_q  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      cmd_cnt <= '0;
      cmd_sr  <= '0;
      out_on  <= 1'b0;
      idx     <= 3'd7;
      snap    <= '0;
    end else if (cs_s) begin
      phase   <= PH_CMD;
      cmd_cnt <= '0;
      cmd_sr  <= '0;
      out_on  <= 1'b0;
      idx     <= 3'd7;
    end else begin
      case (phase)
        PH_CMD: if (sck_rise) begin
          cmd_sr  <= cmd_full[6:0];
          cmd_cnt <= cmd_cnt + 3'd1;
          if (cmd_cnt == 3'd7)
            phase <= (cmd_full == CMD_RDSR) ? PH_STAT : PH_SKIP;
        end
        PH_STAT: if (sck_fall) begin
          if (!out_on) begin
            out_on <= 1'b1;
            idx    <= 3'd7;
            snap   <= live;
          end else begin
            idx <= idx - 3'd1;
            if (idx == 3'd0) snap <= live;
          end
        end
        default: ;
      endcase
    end
  end

  assign so_oe = out_on & ~cs_s & (phase == PH_STAT);
  assign so    = so_oe & ((idx == 3'd7) ? dev_ready : snap[idx]);

  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!out_on && phase == PH_CMD && cmd_cnt == 3'd0)); // R1
  AST_CMD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && phase == PH_CMD && sck_rise && cmd_cnt == 3'd7 && cmd_full == CMD_RDSR)
      |=> (phase == PH_STAT && !out_on)); // R2
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && !cs_s) |=> !so_oe); // R3
  AST_IDX_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && !sck_fall && !cs_s) |=> $stable(idx)); // R4
  AST_WRAP_TO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && sck_fall && idx == 3'd0 && !cs_s) |=> (idx == 3'd7 && so_oe)); // R5
  AST_FRESH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && sck_fall && idx == 3'd0 && !cs_s) |=> snap[6] == $past(cmp_miss)); // R6
  AST_MSB_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && idx == 3'd7 && $stable(idx) && $rose(dev_ready)) |-> so); // R7

endmodule

// File: tb/flash_status_responder_test.sv
module flash_status_responder_test;

  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic dev_ready = 1'b1;
  logic cmp_miss = 1'b0;
  logic so, so_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  flash_status_responder uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .dev_ready(dev_ready), .cmp_miss(cmp_miss), .so(so), .so_oe(so_oe)
  );

  // {mode3, opcode[7:0], ready, miss}
  localparam logic [10:0] VEC [10] = '{
    {1'b0, 8'hD7, 1'b1, 1'b0},
    {1'b0, 8'hD7, 1'b0, 1'b0},
    {1'b1, 8'hD7, 1'b1, 1'b1},
    {1'b1, 8'hD7, 1'b0, 1'b1},
    {1'b0, 8'hD6, 1'b1, 1'b0},
    {1'b1, 8'h57, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'hFF, 1'b1, 1'b0},
    {1'b1, 8'hD7, 1'b1, 1'b0},
    {1'b0, 8'hD7, 1'b0, 1'b1}
  };

  function automatic logic [7:0] status_of(input logic rdy, input logic miss);
    return {rdy, miss, 4'b1011, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_half();
    repeat (H) @(negedge clk);
  endtask

  task automatic start_frame(input logic [7:0] op, input logic mode3);
    @(negedge clk);
    sck = mode3;
    wait_half();
    cs_n = 1'b0;
    wait_half();
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = op[i];
      wait_half();
      sck = 1'b1;
      wait_half();
    end
  endtask

  task automatic read_byte(output logic [7:0] b, output logic oe_all);
    b = '0; oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0;
      wait_half();
      b = {b[6:0], so};
      oe_all &= so_oe;
      sck = 1'b1;
      wait_half();
    end
  endtask

  task automatic end_frame(input logic mode3);
    cs_n = 1'b1;
    sck = mode3;
    wait_half(); wait_half();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic oe;
    logic [7:0] exp;
    logic any_oe;

    repeat (3) @(negedge clk);
    check("R1 reset so_oe", {7'd0, so_oe}, 8'd0);
    check("R1 reset so", {7'd0, so}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle so_oe", {7'd0, so_oe}, 8'd0);

    for (int v = 0; v < 10; v++) begin
      logic m3;
      logic [7:0] op;
      m3 = VEC[v][10]; op = VEC[v][9:2];
      dev_ready = VEC[v][1]; cmp_miss = VEC[v][0];
      start_frame(op, m3);
      if (op == 8'hD7) begin
        exp = status_of(VEC[v][1], VEC[v][0]);
        read_byte(b, oe);
        check("R2 R4 R9 pass1 oe", {7'd0, oe}, 8'd1);
        check("R2 R4 R9 pass1 byte", b, exp);
        read_byte(b, oe);
        check("R5 pass2 byte", b, exp);
      end else begin
        any_oe = 1'b0;
        for (int k = 0; k < 2; k++) begin
          read_byte(b, oe);
          any_oe |= |{oe, b};
        end
        check("R3 wrong opcode silent", {7'd0, any_oe}, 8'd0);
      end
      end_frame(m3);
      check("R1 oe after frame", {7'd0, so_oe}, 8'd0);
    end

    // R7: hold clock low on bit 7, ready rises
    dev_ready = 1'b0; cmp_miss = 1'b0;
    start_frame(8'hD7, 1'b0);
    sck = 1'b0;
    wait_half();
    check("R7 busy on bit7", {6'd0, so_oe, so}, 8'b10);
    repeat (20) @(negedge clk);
    check("R7 still busy", {6'd0, so_oe, so}, 8'b10);
    dev_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 ready seen live", {6'd0, so_oe, so}, 8'b11);
    end_frame(1'b0);

    // R6: compare flag changes mid-pass
    dev_ready = 1'b1; cmp_miss = 1'b0;
    start_frame(8'hD7, 1'b0);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0;
      wait_half();
      b = {b[6:0], so};
      if (i == 0) cmp_miss = 1'b1;
      sck = 1'b1;
      wait_half();
    end
    check("R6 pass keeps copy", b, status_of(1'b1, 1'b0));
    read_byte(b, oe);
    check("R6 next pass fresh", b, status_of(1'b1, 1'b1));
    end_frame(1'b0);

    // R8: abort mid-byte, then fresh frames
    cmp_miss = 1'b0;
    start_frame(8'hD7, 1'b0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; wait_half(); sck = 1'b1; wait_half();
    end
    end_frame(1'b0);
    check("R8 abort releases", {7'd0, so_oe}, 8'd0);
    cs_n = 1'b0;
    any_oe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; wait_half(); any_oe |= so_oe; sck = 1'b1; wait_half();
    end
    check("R8 no output before command", {7'd0, any_oe}, 8'd0);
    end_frame(1'b0);
    start_frame(8'hD7, 1'b0);
    read_byte(b, oe);
    check("R8 new frame works", b, status_of(1'b1, 1'b0));
    end_frame(1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule